// File: doc/BRIEF.md
# Port-Aware PHY Sleep Sequencer

This block decides when a cable PHY may stop its internal clock generators and reference circuits, and when it must bring them back. It watches the host's device power state, the status of every cable port (connected, disabled, suspended), a port interrupt enable, a software wake bit and per-port event detectors. It runs on an always-on slow clock, so the wake-up settle time is counted in cycles of that clock.

Sleep is entered only through a short entry window, and any wake source during that window cancels it. There are two sleep depths. In the shallow depth only the clock generators stop and the references keep running. In the deep depth the references also shut down, and this depth is allowed only while no port could produce an event that needs them. On the way back, a settle count runs before clock-ready is raised. A register access attempted while clock-ready is low raises an access-fail pulse.

Top module: `phy_sleep_ctl`

## Requirements
- R1: After reset, `clk_en`, `ref_en` and `clk_ready` are 1 and `access_fail` is 0.
- R2: A port is inactive when `port_conn`=0, `port_dis`=1 or `port_susp`=1. Sleep entry starts only when all of the following hold: `dev_pstate` is 2 or 3 (encoding 0..3 = D0..D3), every port is inactive, `sw_wake`=0, and no qualified event (R7) is present. Otherwise the block stays awake.
- R3: Once entry starts, `clk_en`, `ref_en` and `clk_ready` stay 1 for exactly ENTRY_CYC (default 4) cycles. The clocks stop on the following edge.
- R4: In shallow sleep, `clk_en`=0, `ref_en`=1 and `clk_ready`=0.
- R5: Deep sleep (`clk_en`=`ref_en`=`clk_ready`=0) is used when every port has `port_conn`=0 or `port_dis`=1 and `port_int_en`=0. While asleep, the block moves between shallow and deep sleep on the next edge after this condition changes.
- R6: From either sleep depth, `sw_wake`=1 leads on the next edge to waking, where `clk_en`=1, `ref_en`=1 and `clk_ready`=0.
- R7: Bit i of an event input is qualified when it is one of these: `ev_bias[i]` with `port_susp[i]`=1, `ev_disc[i]` with `port_susp[i]`=1, or `ev_conn[i]` with `port_dis[i]`=0. A qualified event wakes the block like R6. Event bits that do not qualify have no effect.
- R8: Waking lasts `settle_cycles`+1 cycles, using the value sampled on the wake edge. After that the block is awake with `clk_ready`=1.
- R9: `access_fail` is 1 for one cycle, on the edge after `reg_access`=1 is seen while `clk_ready`=0. It is never raised for an access made while `clk_ready`=1.
- R10: A wake source, or the loss of any entry condition, during the entry window returns the block to awake, and `clk_en` never drops. A later entry restarts the full window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on slow clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_pstate | input | 2 | Host device power state, 0..3 = D0..D3 |
| port_conn | input | N_PORTS | Port connected |
| port_dis | input | N_PORTS | Port disabled |
| port_susp | input | N_PORTS | Port suspended |
| port_int_en | input | 1 | Port event interrupt enable |
| sw_wake | input | 1 | Software wake control bit |
| ev_bias | input | N_PORTS | Incoming bias detected, per port |
| ev_disc | input | N_PORTS | Disconnect detected, per port |
| ev_conn | input | N_PORTS | New connection detected, per port |
| settle_cycles | input | SETTLE_W | Settle count used while waking |
| reg_access | input | 1 | Register access attempt strobe |
| clk_en | output | 1 | Clock generator enable |
| ref_en | output | 1 | Reference circuit enable |
| clk_ready | output | 1 | System clock running and settled |
| access_fail | output | 1 | Access attempted while clock not ready |

## Verification
The three enable outputs are decoded from the state, so a wrong state shows up as a wrong output pattern on the edge it is entered, except that awake and entry look the same at the ports. To tell them apart, the bench times the drop of `clk_en` relative to the cycle in which entry conditions first hold. An early or late drop shows a corrupted entry count or a missed abort within ENTRY_CYC+1 cycles. A wrong settle count shows as `clk_ready` rising on the wrong cycle. A wrong depth shows as `ref_en` being wrong on the first sleep cycle.

// File: rtl/phy_sleep_pkg.sv
`timescale 1ns/1ps
package phy_sleep_pkg;

   typedef enum logic [2:0] {
      PM_ACTIVE = 3'd0,
      PM_ENTRY  = 3'd1,
      PM_LOW    = 3'd2,
      PM_ULTRA  = 3'd3,
      PM_WAKING = 3'd4
   } pm_state_t;

   // D2 and D3 both have the upper bit set
   function automatic logic sleep_pstate(input logic [1:0] ps);
      return ps[1];
   endfunction

endpackage

// File: rtl/phy_port_qual.sv
`timescale 1ns/1ps
module phy_port_qual #(
   parameter int N_PORTS = 3
) (
   input  logic [N_PORTS-1:0] conn,
   input  logic [N_PORTS-1:0] dis,
   input  logic [N_PORTS-1:0] susp,
   input  logic [N_PORTS-1:0] ev_bias,
   input  logic [N_PORTS-1:0] ev_disc,
   input  logic [N_PORTS-1:0] ev_conn,
   output logic               all_idle,
   output logic               all_quiet,
   output logic               wake_evt
);
   logic [N_PORTS-1:0] idle_v;
   logic [N_PORTS-1:0] quiet_v;
   logic [N_PORTS-1:0] wake_v;

   generate
      for (genvar i = 0; i < N_PORTS; i++) begin : g_port
         assign idle_v[i]  = ~conn[i] | dis[i] | susp[i];
         assign quiet_v[i] = ~conn[i] | dis[i];
         assign wake_v[i]  = (susp[i] & (ev_bias[i] | ev_disc[i]))
                           | (~dis[i] & ev_conn[i]);
      end
   endgenerate

   assign all_idle  = &idle_v;
   assign all_quiet = &quiet_v;
   assign wake_evt  = |wake_v;
endmodule

// File: rtl/phy_down_cnt.sv
`timescale 1ns/1ps
module phy_down_cnt #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (load)            cnt_q <= load_val;
      else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

   p_load_takes_r8: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt_q == $past(load_val)));
   p_count_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/phy_sleep_ctl.sv
`timescale 1ns/1ps
module phy_sleep_ctl
   import phy_sleep_pkg::*;
#(
   parameter int N_PORTS       = 3,
   parameter int SETTLE_W      = 6,
   parameter int ENTRY_CYC     = 4,
   parameter int AON_HZ        = 32768,
   parameter int WAKE_LIMIT_US = 2000
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          dev_pstate,
   input  logic [N_PORTS-1:0]  port_conn,
   input  logic [N_PORTS-1:0]  port_dis,
   input  logic [N_PORTS-1:0]  port_susp,
   input  logic                port_int_en,
   input  logic                sw_wake,
   input  logic [N_PORTS-1:0]  ev_bias,
   input  logic [N_PORTS-1:0]  ev_disc,
   input  logic [N_PORTS-1:0]  ev_conn,
   input  logic [SETTLE_W-1:0] settle_cycles,
   input  logic                reg_access,
   output logic                clk_en,
   output logic                ref_en,
   output logic                clk_ready,
   output logic                access_fail
);
   localparam int ENT_W = $clog2(ENTRY_CYC + 1);
   localparam logic [ENT_W-1:0] ENT_LOAD = ENT_W'(ENTRY_CYC - 1);
   localparam longint WORST_WAKE = (64'd1 << SETTLE_W) + 1;

   generate
      if (N_PORTS < 1) begin : g_bad_ports
         $error("N_PORTS must be at least 1");
      end
      if (ENTRY_CYC < 1) begin : g_bad_entry
         $error("ENTRY_CYC must be at least 1");
      end
      if (WORST_WAKE * 1000000 > longint'(AON_HZ) * WAKE_LIMIT_US) begin : g_bad_settle
         $error("SETTLE_W allows a wake longer than WAKE_LIMIT_US");
      end
   endgenerate

   logic all_idle, all_quiet, wake_evt;

   phy_port_qual #(.N_PORTS(N_PORTS)) u_qual (
      .conn     (port_conn),
      .dis      (port_dis),
      .susp     (port_susp),
      .ev_bias  (ev_bias),
      .ev_disc  (ev_disc),
      .ev_conn  (ev_conn),
      .all_idle (all_idle),
      .all_quiet(all_quiet),
      .wake_evt (wake_evt)
   );

   logic wake_any, sleep_ok, deep_ok;
   assign wake_any = sw_wake | wake_evt;
   assign sleep_ok = sleep_pstate(dev_pstate) & all_idle & ~wake_any;
   assign deep_ok  = all_quiet & ~port_int_en;

   pm_state_t st_q, st_d;
   logic ent_load, ent_zero, set_load, set_zero;

   phy_down_cnt #(.W(ENT_W)) u_entry_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (ent_load),
      .load_val(ENT_LOAD),
      .zero    (ent_zero)
   );

   phy_down_cnt #(.W(SETTLE_W)) u_settle_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (set_load),
      .load_val(settle_cycles),
      .zero    (set_zero)
   );

   always_comb begin
      st_d     = st_q;
      ent_load = 1'b0;
      set_load = 1'b0;
      unique case (st_q)
         PM_ACTIVE: if (sleep_ok) begin
            st_d     = PM_ENTRY;
            ent_load = 1'b1;
         end
         PM_ENTRY: begin
            if (!sleep_ok)     st_d = PM_ACTIVE;
            else if (ent_zero) st_d = deep_ok ? PM_ULTRA : PM_LOW;
         end
         PM_LOW: begin
            if (wake_any) begin
               st_d     = PM_WAKING;
               set_load = 1'b1;
            end else if (deep_ok) st_d = PM_ULTRA;
         end
         PM_ULTRA: begin
            if (wake_any) begin
               st_d     = PM_WAKING;
               set_load = 1'b1;
            end else if (!deep_ok) st_d = PM_LOW;
         end
         PM_WAKING: if (set_zero) st_d = PM_ACTIVE;
         default: st_d = PM_ACTIVE;
      endcase
   end

   // outputs registered from the next state: no decode glitches on the enables
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= PM_ACTIVE;
         clk_en      <= 1'b1;
         ref_en      <= 1'b1;
         clk_ready   <= 1'b1;
         access_fail <= 1'b0;
      end else begin
         st_q        <= st_d;
         clk_en      <= (st_d != PM_LOW) && (st_d != PM_ULTRA);
         ref_en      <= (st_d != PM_ULTRA);
         clk_ready   <= (st_d == PM_ACTIVE) || (st_d == PM_ENTRY);
         access_fail <= reg_access & ~clk_ready;
      end
   end

   p_stay_awake_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PM_ACTIVE && !sleep_ok) |=> (st_q == PM_ACTIVE && clk_ready));
   p_drop_after_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(clk_en) |-> ($past(st_q) == PM_ENTRY));
   p_shallow_outputs_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PM_LOW) |-> (!clk_en && ref_en && !clk_ready));
   p_leave_deep_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PM_ULTRA && !wake_any && !deep_ok) |=> (st_q == PM_LOW && ref_en));
   p_wake_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == PM_LOW || st_q == PM_ULTRA) && wake_any)
      |=> (st_q == PM_WAKING && clk_en && ref_en && !clk_ready));
   p_ready_after_settle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_ready) |-> ($past(st_q) == PM_WAKING));
   p_fail_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_access && !clk_ready) |=> access_fail);
   p_no_false_fail_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_access || clk_ready) |=> !access_fail);
   p_abort_keeps_clk_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PM_ENTRY && wake_any) |=> (st_q == PM_ACTIVE && clk_en));
endmodule

// File: tb/sim_phy_sleep_ctl.sv
`timescale 1ns/1ps
module sim_phy_sleep_ctl;
   localparam int NP = 3;
   localparam int SW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    dev_pstate = 2'd0;
   logic [NP-1:0] port_conn = '0, port_dis = '0, port_susp = '0;
   logic          port_int_en = 1'b0, sw_wake = 1'b0, reg_access = 1'b0;
   logic [NP-1:0] ev_bias = '0, ev_disc = '0, ev_conn = '0;
   logic [SW-1:0] settle_cycles = '0;
   logic          clk_en, ref_en, clk_ready, access_fail;

   int checks = 0;
   int errors = 0;

   typedef struct {
      logic [3:0] exp;
      string      tag;
   } exp_t;
   exp_t sb[$];

   always #10 clk = ~clk;

   phy_sleep_ctl #(.N_PORTS(NP), .SETTLE_W(SW)) u0 (
      .clk(clk), .rst_n(rst_n), .dev_pstate(dev_pstate),
      .port_conn(port_conn), .port_dis(port_dis), .port_susp(port_susp),
      .port_int_en(port_int_en), .sw_wake(sw_wake),
      .ev_bias(ev_bias), .ev_disc(ev_disc), .ev_conn(ev_conn),
      .settle_cycles(settle_cycles), .reg_access(reg_access),
      .clk_en(clk_en), .ref_en(ref_en), .clk_ready(clk_ready),
      .access_fail(access_fail)
   );

   // monitor: compare outputs 5 ns after each rising edge
   always begin
      @(posedge clk);
      #5;
      if (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         checks++;
         if ({clk_en, ref_en, clk_ready, access_fail} !== e.exp) begin
            errors++;
            $display("FAIL %s: en/ref/rdy/fail actual %b expected %b",
                     e.tag, {clk_en, ref_en, clk_ready, access_fail}, e.exp);
         end
      end
   end

   // driver: inputs already set at a falling edge; expect result of next rising edge
   task automatic cyc(input logic [3:0] exp, input string tag);
      exp_t e;
      e.exp = exp;
      e.tag = tag;
      sb.push_back(e);
      @(negedge clk);
   endtask

   task automatic cycn(input int n, input logic [3:0] exp, input string tag);
      for (int i = 0; i < n; i++) cyc(exp, tag);
   endtask

   localparam logic [3:0] AWAKE  = 4'b1110;
   localparam logic [3:0] SHALLOW = 4'b0100;
   localparam logic [3:0] DEEP   = 4'b0000;
   localparam logic [3:0] WAKE   = 4'b1100;

   initial begin
      repeat (3) @(negedge clk);
      checks++;
      if ({clk_en, ref_en, clk_ready, access_fail} !== AWAKE) begin
         errors++;
         $display("FAIL R1: in reset actual %b expected %b",
                  {clk_en, ref_en, clk_ready, access_fail}, AWAKE);
      end
      rst_n = 1'b1;
      cyc(AWAKE, "R1");

      // R2: idle ports but D0 -> stays awake, then access while ready gives no fail
      cycn(3, AWAKE, "R2 D0");
      reg_access = 1'b1;
      cyc(AWAKE, "R9 no fail while ready");
      reg_access = 1'b0;

      // R2: D3 with one active port stays awake well past the entry window
      dev_pstate = 2'd3;
      port_conn  = 3'b010;
      cycn(7, AWAKE, "R2 active port");
      // port goes away: full entry window then deep (all disconnected, int_en 0)
      port_conn = 3'b000;
      cycn(4, AWAKE, "R3 entry window");
      cyc(DEEP, "R5 deep entry");
      port_int_en = 1'b1;
      cyc(SHALLOW, "R5 deep to shallow");
      port_int_en = 1'b0;
      cyc(DEEP, "R5 shallow to deep");
      // wake from deep on new connection at non-disabled port
      dev_pstate    = 2'd0;
      settle_cycles = 6'd0;
      ev_conn       = 3'b100;
      cyc(WAKE, "R7 conn wake");
      ev_conn = 3'b000;
      cyc(AWAKE, "R8 settle 0");
      cycn(2, AWAKE, "R8 awake");

      // shallow: D2, all disconnected, int_en 1
      dev_pstate  = 2'd2;
      port_int_en = 1'b1;
      cycn(4, AWAKE, "R3 entry window");
      cyc(SHALLOW, "R4 shallow");
      reg_access = 1'b1;
      cyc(4'b0101, "R9 fail pulse");
      reg_access = 1'b0;
      cyc(SHALLOW, "R9 pulse ends");
      // unqualified events: bias on non-suspended port, conn on disabled port
      ev_bias  = 3'b001;
      port_dis = 3'b010;
      ev_conn  = 3'b010;
      cyc(SHALLOW, "R7 ignored events");
      ev_bias = 3'b000;
      ev_conn = 3'b000;
      port_dis = 3'b000;
      cyc(SHALLOW, "R7 ignored events");
      // software wake, settle 3 -> 4 waking cycles
      sw_wake       = 1'b1;
      dev_pstate    = 2'd0;
      settle_cycles = 6'd3;
      cyc(WAKE, "R6 sw wake");
      sw_wake       = 1'b0;
      settle_cycles = 6'd9; // must not matter after the wake edge
      cycn(3, WAKE, "R8 settling");
      cyc(AWAKE, "R8 ready");
      settle_cycles = 6'd1;

      // suspended port: shallow (connected), bias wake
      dev_pstate  = 2'd2;
      port_int_en = 1'b0;
      port_conn   = 3'b001;
      port_susp   = 3'b001;
      cycn(4, AWAKE, "R3 entry window");
      cyc(SHALLOW, "R5 not deep with connected port");
      ev_disc = 3'b010; // port1 not suspended
      cyc(SHALLOW, "R7 ignored disc");
      ev_disc    = 3'b000;
      ev_bias    = 3'b001;
      dev_pstate = 2'd0;
      cyc(WAKE, "R7 bias wake");
      ev_bias = 3'b000;
      cyc(WAKE, "R8 settle 1");
      cyc(AWAKE, "R8 ready");
      // suspended port disconnect wake
      dev_pstate = 2'd3;
      cycn(4, AWAKE, "R3 entry window");
      cyc(SHALLOW, "R4 shallow");
      ev_disc    = 3'b001;
      dev_pstate = 2'd0;
      cyc(WAKE, "R7 disc wake");
      ev_disc = 3'b000;
      cyc(WAKE, "R8 settle 1");
      cyc(AWAKE, "R8 ready");

      // abort during entry by event, window restarts
      port_conn   = 3'b000;
      port_susp   = 3'b000;
      port_int_en = 1'b1;
      dev_pstate  = 2'd2;
      cycn(2, AWAKE, "R10 entry");
      ev_conn = 3'b010;
      cyc(AWAKE, "R10 abort");
      ev_conn = 3'b000;
      cycn(4, AWAKE, "R10 restarted window");
      cyc(SHALLOW, "R10 sleep after restart");
      // abort by software wake during entry
      sw_wake = 1'b1;
      cyc(WAKE, "R6 wake");
      sw_wake = 1'b0;
      cyc(WAKE, "R8 settle 1");
      cyc(AWAKE, "R8 ready");
      cycn(2, AWAKE, "R10 entry");
      sw_wake = 1'b1;
      cyc(AWAKE, "R10 sw abort");
      cycn(6, AWAKE, "R2 sw held");
      sw_wake    = 1'b0;
      dev_pstate = 2'd0;
      cycn(2, AWAKE, "R2 D0");

      while (sb.size() > 0) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not end, actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule